// File: doc/BRIEF.md
# Core Power Domain Sequencer

This block is a system-side controller that switches the supply of one processor core on and off. It acts on a power-down request and on a power-up request. Between the debug-access gate, the core output clamps, the active-low core reset and the domain power switch it enforces a fixed ordering. No step of a sequence can be reordered or skipped.

Power-down begins only once the core reports that it is idle in wait-for-interrupt standby. From then on the sequence closes debug access, clamps the core outputs, asserts the core reset and removes power. Power-up runs the reverse path. The reset is asserted with debug access closed, and the switch is then enabled. The sequencer waits for power-good, releases the clamps and releases the reset. It then waits for the core to acknowledge that coherency is enabled, and only after that does it open debug access. Each step lasts at least a programmable number of cycles. If power-good does not arrive within a fixed window, the sequencer falls back to a safe fault state.

The software steps are out of scope. This covers cache cleaning, leaving coherency, barriers and state restore, all of which finish before the core signals standby or after debug access opens.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, `state_o` is 0 (off). The outputs are: clamps on, core reset asserted (`core_rst_no`=0), power switch off, debug-powered-up low, busy low, error low.
- R2: `state_o` uses these codes: 0 off, 1 reset step, 2 power step, 3 unclamp step, 4 release step, 5 on, 6 standby wait, 7 debug-off step, 8 clamp step, 9 reset-assert step, 10 fault. On power-up the outputs change in this order: reset asserted with debug low (1), power on (2), clamps off (3), reset released (4), debug-powered-up high (5).
- R3: On power-down, after standby, the outputs change in this order: debug-powered-up low (7), clamps on (8), core reset asserted (9), power off (0).
- R4: With `gap_i`=G, each step state without a wait condition lasts exactly G+1 cycles.
- R5: A power-down request in state 5 moves to state 6. State 6 is left only once `standby_i` is seen high and at least G+1 cycles have passed there.
- R6: State 2 hands over to clamp release only when `pwr_good_i` is high and at least G+1 cycles have passed there.
- R7: If `pwr_good_i` stays low for `TMO_CYC` cycles in state 2, the block enters state 10. There `err_o` is high, the outputs match the off state, and a power-down request is ignored. A power-up request restarts the sequence at state 1.
- R8: Debug-powered-up rises only after `coh_ack_i` is seen high in state 4, and no sooner than G+1 cycles into that state.
- R9: `busy_o` is high in every state except 0, 5 and 10. A request arriving in a busy state, or a request that does not fit a stable state (power-up in 5, power-down in 0), leaves the state and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gap_i | input | GAP_W | Minimum extra cycles per step |
| down_req_i | input | 1 | Power-down request |
| up_req_i | input | 1 | Power-up request |
| standby_i | input | 1 | Core idle in wait-for-interrupt |
| pwr_good_i | input | 1 | Domain supply is good |
| coh_ack_i | input | 1 | Core coherency enabled |
| dbg_pwrup_o | output | 1 | Debug access allowed |
| clamp_o | output | 1 | Core output clamps enabled |
| core_rst_no | output | 1 | Core power-on reset, active low |
| pwr_en_o | output | 1 | Domain power switch enable |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Power-good timeout fault |
| state_o | output | 4 | Current state code |

## Verification
The bench sweeps every gap value of a 3-bit configuration. Each wait input is released either at once or late, so the dwell in every state is checked against max(release, G)+1. A design that skips the gap, or that acts on a wait input too early, shows a dwell that is too short. One that swaps two steps shows the wrong output pattern in a state.

Requests are injected into busy states and into stable states where they do not fit. A leaky request handler would then change state or cut a sequence short. A supply that never reports good must produce the fault state after exactly `TMO_CYC` cycles, with the outputs made safe. An off-by-one timeout shifts the dwell, and a fault that keeps power on shows up as a wrong output pattern.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [3:0] {
    ST_OFF     = 4'd0,
    ST_U_RST   = 4'd1,
    ST_U_PWR   = 4'd2,
    ST_U_CLAMP = 4'd3,
    ST_U_REL   = 4'd4,
    ST_ON      = 4'd5,
    ST_D_SB    = 4'd6,
    ST_D_DBG   = 4'd7,
    ST_D_CLAMP = 4'd8,
    ST_D_RST   = 4'd9,
    ST_FAULT   = 4'd10
  } cps_state_e;

  typedef struct packed {
    logic dbg;
    logic clamp;
    logic rst_n;
    logic pwr;
    logic busy;
    logic err;
  } cps_drive_t;
endpackage

// File: rtl/cps_timer.sv
module cps_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (clr_i)           cnt_o <= '0;
    else if (cnt_o != '1)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
  import cps_pkg::*;
#(
  parameter int GAP_W   = 4,
  parameter int TMO_CYC = 64,
  parameter int CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GAP_W-1:0] gap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             down_req_i,
  input  logic             up_req_i,
  input  logic             standby_i,
  input  logic             pwr_good_i,
  input  logic             coh_ack_i,
  output cps_state_e       state_o,
  output logic             step_o
);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);

  cps_state_e state_q, state_d;
  logic       gap_ok;

  assign gap_ok = cnt_i >= CNT_W'(gap_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF, ST_FAULT: if (up_req_i) state_d = ST_U_RST;
      ST_U_RST:   if (gap_ok) state_d = ST_U_PWR;
      ST_U_PWR: begin
        if (gap_ok && pwr_good_i)                state_d = ST_U_CLAMP;
        else if (!pwr_good_i && cnt_i >= TMO_LAST) state_d = ST_FAULT;
      end
      ST_U_CLAMP: if (gap_ok) state_d = ST_U_REL;
      ST_U_REL:   if (gap_ok && coh_ack_i) state_d = ST_ON;
      ST_ON:      if (down_req_i) state_d = ST_D_SB;
      ST_D_SB:    if (gap_ok && standby_i) state_d = ST_D_DBG;
      ST_D_DBG:   if (gap_ok) state_d = ST_D_CLAMP;
      ST_D_CLAMP: if (gap_ok) state_d = ST_D_RST;
      ST_D_RST:   if (gap_ok) state_d = ST_OFF;
      default:    state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign step_o  = state_d != state_q;
endmodule

// File: rtl/cps_decode.sv
module cps_decode
  import cps_pkg::*;
(
  input  cps_state_e state_i,
  output cps_drive_t drv_o
);
  always_comb begin
    // idle-off pattern: clamps on, reset low, power off
    drv_o = '{dbg: 1'b0, clamp: 1'b1, rst_n: 1'b0, pwr: 1'b0, busy: 1'b1, err: 1'b0};
    unique case (state_i)
      ST_OFF:     drv_o.busy = 1'b0;
      ST_FAULT:   begin drv_o.busy = 1'b0; drv_o.err = 1'b1; end
      ST_U_RST:   ;
      ST_U_PWR:   drv_o.pwr = 1'b1;
      ST_U_CLAMP: begin drv_o.pwr = 1'b1; drv_o.clamp = 1'b0; end
      ST_U_REL:   begin drv_o.pwr = 1'b1; drv_o.clamp = 1'b0; drv_o.rst_n = 1'b1; end
      ST_ON:      drv_o = '{dbg: 1'b1, clamp: 1'b0, rst_n: 1'b1, pwr: 1'b1, busy: 1'b0, err: 1'b0};
      ST_D_SB:    drv_o = '{dbg: 1'b1, clamp: 1'b0, rst_n: 1'b1, pwr: 1'b1, busy: 1'b1, err: 1'b0};
      ST_D_DBG:   begin drv_o.pwr = 1'b1; drv_o.clamp = 1'b0; drv_o.rst_n = 1'b1; end
      ST_D_CLAMP: begin drv_o.pwr = 1'b1; drv_o.rst_n = 1'b1; end
      ST_D_RST:   drv_o.pwr = 1'b1;
      default:    ;
    endcase
  end
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import cps_pkg::*;
#(
  parameter int GAP_W   = 4,
  parameter int TMO_CYC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             down_req_i,
  input  logic             up_req_i,
  input  logic             standby_i,
  input  logic             pwr_good_i,
  input  logic             coh_ack_i,
  output logic             dbg_pwrup_o,
  output logic             clamp_o,
  output logic             core_rst_no,
  output logic             pwr_en_o,
  output logic             busy_o,
  output logic             err_o,
  output logic [3:0]       state_o
);
  localparam int GAP_MAX = (1 << GAP_W) - 1;
  localparam int CNT_MAX = (TMO_CYC > GAP_MAX) ? TMO_CYC : GAP_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic             step;
  cps_state_e       state;
  cps_drive_t       drv;

  cps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (step),
    .cnt_o  (cnt)
  );

  cps_fsm #(.GAP_W(GAP_W), .TMO_CYC(TMO_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gap_i      (gap_i),
    .cnt_i      (cnt),
    .down_req_i (down_req_i),
    .up_req_i   (up_req_i),
    .standby_i  (standby_i),
    .pwr_good_i (pwr_good_i),
    .coh_ack_i  (coh_ack_i),
    .state_o    (state),
    .step_o     (step)
  );

  cps_decode u_dec (
    .state_i (state),
    .drv_o   (drv)
  );

  assign dbg_pwrup_o = drv.dbg;
  assign clamp_o     = drv.clamp;
  assign core_rst_no = drv.rst_n;
  assign pwr_en_o    = drv.pwr;
  assign busy_o      = drv.busy;
  assign err_o       = drv.err;
  assign state_o     = state;

  // R2
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_no) |-> !clamp_o && pwr_en_o);
  // R3
  pwr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> clamp_o && !core_rst_no && !dbg_pwrup_o);
  // R5
  dbg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dbg_pwrup_o) |-> $past(standby_i));
  // R6
  unclamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clamp_o) && pwr_en_o) |-> $past(pwr_good_i));
  // R7
  fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(!pwr_good_i) && !pwr_en_o && clamp_o);
  // R8
  dbg_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_pwrup_o) |-> $past(coh_ack_i) && core_rst_no);
endmodule

// File: tb/core_pwr_seq_test.sv
module core_pwr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_W      = 3;
  localparam int TMO        = 20;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [GAP_W-1:0] gap_i = '0;
  logic             down_req_i = 1'b0, up_req_i = 1'b0;
  logic             standby_i = 1'b0, pwr_good_i = 1'b0, coh_ack_i = 1'b0;
  logic             dbg_pwrup_o, clamp_o, core_rst_no, pwr_en_o, busy_o, err_o;
  logic [3:0]       state_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  core_pwr_seq #(.GAP_W(GAP_W), .TMO_CYC(TMO)) uut (
    .clk_i, .rst_ni, .gap_i, .down_req_i, .up_req_i, .standby_i,
    .pwr_good_i, .coh_ack_i, .dbg_pwrup_o, .clamp_o, .core_rst_no,
    .pwr_en_o, .busy_o, .err_o, .state_o
  );

  function automatic logic [9:0] obs();
    return {state_o, dbg_pwrup_o, clamp_o, core_rst_no, pwr_en_o, busy_o, err_o};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic now(input logic [3:0] st, input logic [5:0] drv, input string tag);
    chk(obs() == {st, drv}, tag, obs(), {st, drv});
  endtask

  task automatic pulse(input bit up);
    if (up) up_req_i = 1'b1; else down_req_i = 1'b1;
    @(negedge clk_i);
    up_req_i = 1'b0; down_req_i = 1'b0;
  endtask

  // rel_sel: 1 power-good, 2 coherency ack, 3 standby; inj: 1 up, 2 down
  task automatic step(input logic [3:0] st, input logic [5:0] drv, input int dwell,
                      input int rel_sel, input int rel_at, input int inj, input string tag);
    int n;
    now(st, drv, tag);
    n = 0;
    while (1) begin
      if (n == rel_at) begin
        if (rel_sel == 1) pwr_good_i = 1'b1;
        if (rel_sel == 2) coh_ack_i  = 1'b1;
        if (rel_sel == 3) standby_i  = 1'b1;
      end
      if (n == 0 && inj == 1) up_req_i = 1'b1;
      if (n == 0 && inj == 2) down_req_i = 1'b1;
      @(negedge clk_i);
      n++;
      up_req_i = 1'b0; down_req_i = 1'b0;
      if (state_o != st || n > 300) break;
    end
    chk(n == dwell, {tag, " dwell"}, n, dwell);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    now(4'd0, 6'b010000, "R1 reset state");

    for (int g = 0; g < 8; g++) begin
      for (int v = 0; v < 2; v++) begin
        int k, d, dk;
        k  = v ? g + 2 : 0;
        d  = g + 1;
        dk = ((k > g) ? k : g) + 1;
        gap_i = GAP_W'(g);
        pwr_good_i = 1'b0; coh_ack_i = 1'b0; standby_i = 1'b0;
        pulse(1'b0);
        now(4'd0, 6'b010000, "R9 down ignored in off");
        pulse(1'b1);
        step(4'd1, 6'b010010, d,  0, 0, 0, "R2 R4 up reset step");
        step(4'd2, 6'b010110, dk, 1, k, 2, "R6 R9 power step");
        step(4'd3, 6'b000110, d,  0, 0, 0, "R2 R4 unclamp step");
        step(4'd4, 6'b001110, dk, 2, k, 1, "R8 release step");
        now(4'd5, 6'b101100, "R2 on state");
        pulse(1'b1);
        now(4'd5, 6'b101100, "R9 up ignored in on");
        pulse(1'b0);
        step(4'd6, 6'b101110, dk, 3, k, 0, "R5 standby wait");
        step(4'd7, 6'b001110, d,  0, 0, 0, "R3 R4 debug-off step");
        step(4'd8, 6'b011110, d,  0, 0, 1, "R3 R9 clamp step");
        step(4'd9, 6'b010110, d,  0, 0, 0, "R3 R4 reset-assert step");
        now(4'd0, 6'b010000, "R3 off reached");
      end
    end

    // R7 power-good timeout
    gap_i = 3'd3;
    pwr_good_i = 1'b0; coh_ack_i = 1'b0; standby_i = 1'b0;
    pulse(1'b1);
    step(4'd1, 6'b010010, 4, 0, 0, 0, "R7 reset step");
    step(4'd2, 6'b010110, TMO, 0, 0, 0, "R7 timeout");
    now(4'd10, 6'b010001, "R7 fault outputs");
    pulse(1'b0);
    now(4'd10, 6'b010001, "R7 down ignored in fault");
    pulse(1'b1);
    step(4'd1, 6'b010010, 4, 0, 0, 0, "R7 restart");
    step(4'd2, 6'b010110, 4, 1, 0, 0, "R7 restart power");
    step(4'd3, 6'b000110, 4, 0, 0, 0, "R7 restart unclamp");
    step(4'd4, 6'b001110, 4, 2, 0, 0, "R7 restart release");
    now(4'd5, 6'b101100, "R7 on after restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule